// File: doc/BRIEF.md
# Serial Configuration Port with Chain Output

This block receives the settings of a two-channel frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. Bits enter a 21-bit shift register, most significant bit first. When the load strobe rises, the 19 upper bits of that register are copied into one of four holding registers. The two bits shifted in last pick which one. The holding registers carry a reference divider for each channel, a main counter, a swallow counter and a fractional value. Their fields are presented as parallel outputs.

A single output pin can carry the top shift-register stage, so several ports can be wired in a chain, each one's pin feeding the next one's data line. That stage moves onto the pin on the falling serial-clock edge, half a bit period after capture, which gives the next device a full half period of setup. A select field in the channel-1 reference register can instead force the pin to a constant level.

The three serial inputs are asynchronous to the block's system clock `clk`. Each passes through a synchronizer before use, and edges are detected in the `clk` domain. The serial clock must therefore run well below `clk`.

Top module: `scfg_port`

## Requirements
- R1: On each rising serial-clock edge seen while load enable is low, the shift register moves up one place and takes `sdata` into bit 0, so after 21 edges bit 20 holds the first bit sent.
- R2: While load enable is high, serial-clock edges leave the shift register unchanged.
- R3: On a rising edge of load enable, shift bits [20:2] are copied into the register selected by shift bits [1:0]: 00 channel-1 reference, 01 channel-1 main, 10 channel-2 reference, 11 channel-2 main. The other three registers keep their contents.
- R4: Field layout within the 19 stored bits: channel-1 reference divider in [8:0] and pin select in [10:9]; channel-1 main counter in [18:10], swallow in [9:5] and fraction in [4:0]; channel-2 reference divider in [8:0]; channel-2 main counter in [17:9], swallow in [8:5] and fraction in [4:0].
- R5: Frame length is not checked: a load after fewer or more than 21 clocks transfers the last 21 bits the shift register holds.
- R6: In chain mode, the pin takes shift bit 20 on each falling serial-clock edge and does not change on a rising edge.
- R7: Pin select 00 gives chain data, 10 drives the pin high, and 01 or 11 drive it low.
- R8: After reset all fields read zero, the pin select is chain, and the pin is low.
- R9: A serial-clock or load-enable transition applied between `clk` edges takes effect at the third following rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data, MSB first |
| le | input | 1 | Load enable; rising edge transfers the word |
| ch1_ref_div | output | 9 | Channel-1 reference divider |
| ch1_main | output | 9 | Channel-1 main counter |
| ch1_swallow | output | 5 | Channel-1 swallow counter |
| ch1_frac | output | 5 | Channel-1 fractional value |
| ch2_ref_div | output | 9 | Channel-2 reference divider |
| ch2_main | output | 9 | Channel-2 main counter |
| ch2_swallow | output | 4 | Channel-2 swallow counter |
| ch2_frac | output | 5 | Channel-2 fractional value |
| mux_out | output | 1 | Multipurpose pin: chain data or constant level |

## Verification
The bench feeds a second frame behind a first and reads the pin just before every rising serial edge. A port that updated the pin on the rising edge, or took a stage other than bit 20, would return the first frame out of order or shifted by one bit. Short and long frames are loaded. A design that counted bits or cleared the register would then load the wrong fields or ignore the load. Serial clocks sent while load enable is high must leave both the pin and a repeated load unchanged. A load on the wrong cycle, or a pin select that confused its constant codes with chain mode, shows up against the per-cycle reference model.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int SR_W    = 21;
    localparam int ADDR_W  = 2;
    localparam int PAY_W   = SR_W - ADDR_W;
    localparam int NREG    = 1 << ADDR_W;
    localparam int DIV_W   = 9;
    localparam int SW1_W   = 5;
    localparam int SW2_W   = 4;
    localparam int FRAC_W  = 5;
    localparam int SEL_W   = 2;

    localparam int FRAC_LSB  = 0;
    localparam int SW_LSB    = FRAC_LSB + FRAC_W;
    localparam int MAIN1_LSB = SW_LSB + SW1_W;
    localparam int MAIN2_LSB = SW_LSB + SW2_W;
    localparam int SEL_LSB   = DIV_W;

    localparam logic [ADDR_W-1:0] ADR_CH1_REF  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CH1_MAIN = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CH2_REF  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CH2_MAIN = 2'd3;

    typedef logic [PAY_W-1:0] payload_t;

    typedef enum logic [SEL_W-1:0] {
        PIN_CHAIN   = 2'b00,
        PIN_LOW     = 2'b01,
        PIN_HIGH    = 2'b10,
        PIN_LOW_ALT = 2'b11
    } pin_sel_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
    parameter int SR_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_lvl,
    input  logic            sdata_lvl,
    input  logic            le_lvl,
    output logic [SR_W-1:0] sr_o,
    output logic            load_o,
    output logic            chain_o,
    output logic            sclk_rise_o,
    output logic            sclk_fall_o
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            chain;
        logic            sclk_prev;
        logic            le_prev;
    } shf_state_t;

    shf_state_t st_d, st_q;
    logic rise, fall, load;

    always_comb begin
        rise = sclk_lvl & ~st_q.sclk_prev;
        fall = ~sclk_lvl & st_q.sclk_prev;
        load = le_lvl & ~st_q.le_prev;

        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        st_d.le_prev   = le_lvl;
        if (rise && !le_lvl) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdata_lvl};
        end
        if (fall) begin
            st_d.chain = st_q.sr[SR_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o        = st_q.sr;
    assign load_o      = load;
    assign chain_o     = st_q.chain;
    assign sclk_rise_o = rise;
    assign sclk_fall_o = fall;
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank #(
    parameter int PAY_W  = 19,
    parameter int ADDR_W = 2,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [PAY_W-1:0]      payload,
    output logic [NREG*PAY_W-1:0] bank_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(g);

        logic [PAY_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (load && (addr == MY_ADR)) begin
                word_d = payload;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign bank_o[g*PAY_W +: PAY_W] = word_q;
    end
endmodule

// File: rtl/scfg_port.sv
module scfg_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              le,
    output logic [DIV_W-1:0]  ch1_ref_div,
    output logic [DIV_W-1:0]  ch1_main,
    output logic [SW1_W-1:0]  ch1_swallow,
    output logic [FRAC_W-1:0] ch1_frac,
    output logic [DIV_W-1:0]  ch2_ref_div,
    output logic [DIV_W-1:0]  ch2_main,
    output logic [SW2_W-1:0]  ch2_swallow,
    output logic [FRAC_W-1:0] ch2_frac,
    output logic              mux_out
);
    logic [2:0] raw_in, sync_in;
    logic       sclk_lvl, sdata_lvl, le_lvl;
    logic [SR_W-1:0] sr_word;
    logic       load_stb, chain_bit, sclk_rise, sclk_fall;
    logic [NREG*PAY_W-1:0] bank_flat;
    payload_t   w_ref1, w_main1, w_ref2, w_main2;
    pin_sel_e   pin_sel;
    logic       unused_bits;

    assign raw_in = {le, sdata, sclk};

    scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    assign sclk_lvl  = sync_in[0];
    assign sdata_lvl = sync_in[1];
    assign le_lvl    = sync_in[2];

    scfg_shifter #(.SR_W(SR_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_lvl   (sclk_lvl),
        .sdata_lvl  (sdata_lvl),
        .le_lvl     (le_lvl),
        .sr_o       (sr_word),
        .load_o     (load_stb),
        .chain_o    (chain_bit),
        .sclk_rise_o(sclk_rise),
        .sclk_fall_o(sclk_fall)
    );

    scfg_bank #(.PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_stb),
        .addr   (sr_word[ADDR_W-1:0]),
        .payload(sr_word[SR_W-1:ADDR_W]),
        .bank_o (bank_flat)
    );

    assign w_ref1  = bank_flat[int'(ADR_CH1_REF)*PAY_W  +: PAY_W];
    assign w_main1 = bank_flat[int'(ADR_CH1_MAIN)*PAY_W +: PAY_W];
    assign w_ref2  = bank_flat[int'(ADR_CH2_REF)*PAY_W  +: PAY_W];
    assign w_main2 = bank_flat[int'(ADR_CH2_MAIN)*PAY_W +: PAY_W];

    assign ch1_ref_div = w_ref1[0 +: DIV_W];
    assign ch1_main    = w_main1[MAIN1_LSB +: DIV_W];
    assign ch1_swallow = w_main1[SW_LSB +: SW1_W];
    assign ch1_frac    = w_main1[FRAC_LSB +: FRAC_W];
    assign ch2_ref_div = w_ref2[0 +: DIV_W];
    assign ch2_main    = w_main2[MAIN2_LSB +: DIV_W];
    assign ch2_swallow = w_main2[SW_LSB +: SW2_W];
    assign ch2_frac    = w_main2[FRAC_LSB +: FRAC_W];

    assign pin_sel = pin_sel_e'(w_ref1[SEL_LSB +: SEL_W]);

    always_comb begin
        case (pin_sel)
            PIN_CHAIN: mux_out = chain_bit;
            PIN_HIGH:  mux_out = 1'b1;
            default:   mux_out = 1'b0;
        endcase
    end

    assign unused_bits = ^{w_ref1[PAY_W-1:SEL_LSB+SEL_W],
                           w_ref2[PAY_W-1:DIV_W],
                           w_main2[PAY_W-1:MAIN2_LSB+DIV_W]};
endmodule

// File: rtl/scfg_port_chk.sv
module scfg_port_chk
    import scfg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk_rise,
    input logic                  sclk_fall,
    input logic                  le_lvl,
    input logic                  load_stb,
    input logic [SR_W-1:0]       sr_word,
    input logic                  chain_bit,
    input logic [NREG*PAY_W-1:0] bank_flat
);
    // R1: a qualified rising serial edge moves every stage up by one
    a_r1_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !le_lvl) |=> (sr_word[SR_W-1:1] == $past(sr_word[SR_W-2:0])));

    // R2: shift register frozen while load enable is high
    a_r2_frozen_le_high: assert property (@(posedge clk) disable iff (!rst_n)
        le_lvl |=> $stable(sr_word));

    // R3: holding registers change only on a load strobe
    a_r3_bank_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(bank_flat));

    // R6: chain stage changes only on a falling serial edge
    a_r6_chain_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(chain_bit));
endmodule

bind scfg_port scfg_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .le_lvl   (le_lvl),
    .load_stb (load_stb),
    .sr_word  (sr_word),
    .chain_bit(chain_bit),
    .bank_flat(bank_flat)
);

// File: tb/tb_scfg_port.sv
`timescale 1ns/1ps
module tb_scfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
    logic [8:0] ch1_ref_div, ch1_main, ch2_ref_div, ch2_main;
    logic [4:0] ch1_swallow, ch1_frac, ch2_frac;
    logic [3:0] ch2_swallow;
    logic mux_out;

    always #10 clk = ~clk;

    scfg_port dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .le(le),
        .ch1_ref_div(ch1_ref_div), .ch1_main(ch1_main),
        .ch1_swallow(ch1_swallow), .ch1_frac(ch1_frac),
        .ch2_ref_div(ch2_ref_div), .ch2_main(ch2_main),
        .ch2_swallow(ch2_swallow), .ch2_frac(ch2_frac),
        .mux_out(mux_out)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic chk_mid = 1'b0;
    logic cap [0:63];
    int   cap_n = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: inputs act three clk edges after they are applied (R9)
    logic [2:0]  h0 = 3'b0, h1 = 3'b0, h2 = 3'b0;
    logic [20:0] m_sr = '0;
    logic        m_chain = 1'b0;
    logic [18:0] m_bank [0:3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 = 3'b0; h1 = 3'b0; h2 = 3'b0;
            m_sr = '0; m_chain = 1'b0;
            for (int i = 0; i < 4; i++) m_bank[i] = '0;
        end else begin
            if (h2[0] && !h1[0]) m_chain = m_sr[20];
            if (h1[2] && !h2[2]) m_bank[m_sr[1:0]] = m_sr[20:2];
            if (h1[0] && !h2[0] && !h1[2]) m_sr = {m_sr[19:0], h1[1]};
            h2 = h1; h1 = h0; h0 = {le, sdata, sclk};
        end
    end

    function automatic logic exp_pin();
        case (m_bank[0][10:9])
            2'b00:   return m_chain;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // per-cycle comparison of all outputs against the model (R4, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 fields per cycle",
                {ch1_ref_div, ch1_main, ch1_swallow, ch1_frac,
                 ch2_ref_div, ch2_main, ch2_swallow, ch2_frac},
                {m_bank[0][8:0], m_bank[1][18:10], m_bank[1][9:5], m_bank[1][4:0],
                 m_bank[2][8:0], m_bank[3][17:9], m_bank[3][8:5], m_bank[3][4:0]});
            chk("R7 pin per cycle", mux_out, exp_pin());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic send_bit(input logic b);
        logic pre;
        @(negedge clk); sdata = b;
        repeat (3) @(negedge clk);
        pre = mux_out;
        if (cap_n < 64) cap[cap_n] = pre;
        cap_n++;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        if (chk_mid) chk("R6 pin steady across rising edge", mux_out, pre);
        @(negedge clk); sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        @(negedge clk); le = 1'b1;
        repeat (5) @(negedge clk);
        le = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [20:0] w_ref1(input logic [8:0] r, input logic [1:0] s);
        return {8'd0, s, r, 2'b00};
    endfunction
    function automatic logic [20:0] w_main1(input logic [8:0] m, input logic [4:0] a, input logic [4:0] f);
        return {m, a, f, 2'b01};
    endfunction
    function automatic logic [20:0] w_ref2(input logic [8:0] r);
        return {10'd0, r, 2'b10};
    endfunction
    function automatic logic [20:0] w_main2(input logic [8:0] m, input logic [3:0] a, input logic [4:0] f);
        return {1'b0, m, a, f, 2'b11};
    endfunction

    initial begin
        logic [20:0] wa, wb, ex;
        logic [24:0] wl;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R8: reset state
        chk("R8 fields zero after reset",
            {ch1_ref_div, ch1_main, ch1_swallow, ch1_frac,
             ch2_ref_div, ch2_main, ch2_swallow, ch2_frac}, 64'd0);
        chk("R8 pin low after reset", mux_out, 1'b0);

        // R3, R4: each register and its fields
        shift_bits(32'(w_main1(9'h1A5, 5'h13, 5'h0B)), 21); pulse_le();
        chk("R4 ch1 main fields", {ch1_main, ch1_swallow, ch1_frac}, {9'h1A5, 5'h13, 5'h0B});
        chk("R3 other registers untouched", {ch1_ref_div, ch2_ref_div, ch2_main}, 64'd0);
        shift_bits(32'(w_ref1(9'h12C, 2'b00)), 21); pulse_le();
        chk("R3 ch1 ref loaded", ch1_ref_div, 9'h12C);
        chk("R3 ch1 main kept", {ch1_main, ch1_swallow, ch1_frac}, {9'h1A5, 5'h13, 5'h0B});
        shift_bits(32'(w_ref2(9'h0FF)), 21); pulse_le();
        chk("R3 ch2 ref loaded", ch2_ref_div, 9'h0FF);
        shift_bits(32'(w_main2(9'h155, 4'hA, 5'h1F)), 21); pulse_le();
        chk("R4 ch2 main fields", {ch2_main, ch2_swallow, ch2_frac}, {9'h155, 4'hA, 5'h1F});

        // R9: load latency of three clk edges
        shift_bits(32'(w_ref2(9'h003)), 21);
        @(negedge clk); le = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 no load after two edges", ch2_ref_div, 9'h0FF);
        @(negedge clk);
        chk("R9 load at third edge", ch2_ref_div, 9'h003);
        repeat (3) @(negedge clk); le = 1'b0;
        repeat (5) @(negedge clk);

        // R6, R1: chain output returns the previous frame MSB first
        wa = w_main1(9'h15A, 5'h13, 5'h0B);
        wb = w_main2(9'h0F3, 4'h5, 5'h16);
        chk_mid = 1'b1;
        shift_bits(32'(wa), 21);
        cap_n = 0;
        shift_bits(32'(wb), 21);
        for (int i = 0; i < 21; i++) chk("R6 chain bit order", cap[i], wa[20 - i]);
        pulse_le();
        chk("R1 ch2 main after chained frame", {ch2_main, ch2_swallow, ch2_frac}, {9'h0F3, 4'h5, 5'h16});

        // R2: clocks while le high have no effect
        shift_bits(32'(wa), 21); pulse_le();
        chk("R2 ch1 main loaded", {ch1_main, ch1_swallow, ch1_frac}, {9'h15A, 5'h13, 5'h0B});
        @(negedge clk); le = 1'b1;
        repeat (5) @(negedge clk);
        shift_bits(32'h2A, 6);
        chk("R2 pin unchanged while le high", mux_out, wa[20]);
        le = 1'b0;
        repeat (5) @(negedge clk);
        pulse_le();
        chk("R2 reload gives same word", {ch1_main, ch1_swallow, ch1_frac}, {9'h15A, 5'h13, 5'h0B});
        chk_mid = 1'b0;

        // R5: short frame
        shift_bits(32'(w_ref2(9'h1FF)), 21);
        shift_bits(32'h2B5, 10);
        pulse_le();
        ex = 21'((32'(w_ref2(9'h1FF)) << 10) | 32'h2B5);
        chk("R5 short frame loads shifted content",
            {ch1_main, ch1_swallow, ch1_frac}, {ex[20:12], ex[11:7], ex[6:2]});
        // R5: long frame
        wl = 25'h1ABCDE7;
        shift_bits(32'(wl), 25);
        pulse_le();
        chk("R5 long frame keeps last 21 bits",
            {ch2_main, ch2_swallow, ch2_frac}, {wl[19:11], wl[10:7], wl[6:2]});

        // R7: pin select codes
        shift_bits(32'(w_ref1(9'h0AA, 2'b10)), 21); pulse_le();
        chk("R7 select 10 drives high", mux_out, 1'b1);
        shift_bits(32'(w_ref1(9'h0AA, 2'b01)), 21); pulse_le();
        shift_bits(32'h1FFFFF, 21);
        chk("R7 select 01 drives low despite chain 1", mux_out, 1'b0);
        shift_bits(32'(w_ref1(9'h0AA, 2'b11)), 21); pulse_le();
        shift_bits(32'h1FFFFF, 21);
        chk("R7 select 11 drives low despite chain 1", mux_out, 1'b0);
        shift_bits(32'(w_ref1(9'h0AA, 2'b00)), 21); pulse_le();
        shift_bits(32'h1FFFFF, 21);
        chk("R7 select 00 gives chain data", mux_out, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule